// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Dispatcher

This block collects a vector of level-held interrupt lines (32 or 64 of them, chosen at build time), gates them with an enable mask that software maintains, and presents the result as one summary request to the processor. When the processor asks for service, the block returns the number of one pending line. It has no fixed priority. A rotating pointer remembers where the previous grant stopped, and the next search starts one position after it, so a line that stays asserted cannot starve its neighbours.

A contiguous window of line indices can be declared as cascaded external inputs. A grant that falls inside the window is flagged external and is numbered from zero at the bottom of the window. Every other grant is flagged internal and carries its raw index. Software can replace the whole mask in one write, or it can enable or disable a single line without disturbing the other bits.

Top module: `rr_irq_dispatch`

## Requirements
- R1: `pending` equals `raw_status` AND `mask_q` bit for bit, and `cpu_irq` is high exactly when `pending` is non-zero. Both follow the inputs combinationally, and a mask bit of 1 enables its line.
- R2: While `rst_n` is low at a clock edge, the mask, the rotating pointer and `grant_valid` are cleared to zero.
- R3: If `svc_req` is high at an edge while `pending` is zero, then `grant_valid` is low after that edge and the pointer keeps its value.
- R4: If `svc_req` is high at an edge while `pending` is non-zero, the block grants the first pending index found by checking the pointer position, then pointer+1, and so on, wrapping modulo the line count. `grant_valid` is high for the one cycle after that edge.
- R5: After a grant at index g, the pointer holds (g+1) modulo the line count, so the next search begins just past g.
- R6: With cascading enabled, a granted index g with EXT_FIRST <= g <= EXT_LAST gives `grant_ext`=1 and `grant_num`=g-EXT_FIRST. Any other index gives `grant_ext`=0 and `grant_num`=g.
- R7: When `mask_wr_en` is high at an edge, `mask_q` takes the value of `mask_wr_data`.
- R8: When `line_op_en` is high and `mask_wr_en` is low, `line_op_set`=1 sets mask bit `line_op_idx` and `line_op_set`=0 clears it. All other mask bits keep their values. A full write in the same cycle wins over the single-line operation.
- R9: If `svc_req` is low at an edge, `grant_valid` is low after that edge and the pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_status | input | NUM_LINES | Level-held interrupt sources |
| mask_wr_en | input | 1 | Load the whole mask |
| mask_wr_data | input | NUM_LINES | New mask value |
| line_op_en | input | 1 | Single-line enable/disable strobe |
| line_op_set | input | 1 | 1 enables the line, 0 disables it |
| line_op_idx | input | $clog2(NUM_LINES) | Line addressed by the single-line operation |
| mask_q | output | NUM_LINES | Current enable mask |
| pending | output | NUM_LINES | Status AND mask |
| cpu_irq | output | 1 | Summary request to the processor |
| svc_req | input | 1 | Service request from the processor |
| grant_valid | output | 1 | A grant was produced for the last request |
| grant_ext | output | 1 | Granted line lies in the cascaded window |
| grant_num | output | $clog2(NUM_LINES) | Granted number, internal or external space |

## Verification
The embedded assertions check several properties on every cycle. A grant always names a line that was pending at the request edge. The pointer ends one position past the granted index. A request with nothing pending, or no request at all, leaves `grant_valid` low and the pointer unchanged. External numbers stay inside the window size. A single-line operation changes no mask bit except the one it addresses. The fairness of the rotation needs the bench's behavioural reference, which tracks its own pointer across sequences of grants. That covers wrap-around from the top index to zero, the exact ordering of grants, the remapped numbers near both edges of the cascaded window, and the priority of a full write over a single-line operation in the same cycle.

// File: rtl/rrid_pkg.sv
// Shared definitions for the round-robin interrupt dispatcher.
// Assumes: nothing beyond IEEE 1800-2017.
package rrid_pkg;
    // Kind of a single-line mask operation.
    typedef enum logic {
        LINE_DISABLE = 1'b0,
        LINE_ENABLE  = 1'b1
    } line_op_e;
endpackage

// File: rtl/rrid_mask_reg.sv
// Enable-mask register. It supports a whole-word load and a single-bit
// set or clear. The whole-word load takes priority when both occur in one cycle.
// Assumes: synchronous active-low reset, and an index below NUM_LINES.
module rrid_mask_reg #(
    parameter int NUM_LINES = 32,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    input  logic                 op_en,
    input  rrid_pkg::line_op_e   op_kind,
    input  logic [IDX_W-1:0]     op_idx,
    output logic [NUM_LINES-1:0] mask_q
);
    logic [NUM_LINES-1:0] sel_bit;

    // Decode the addressed line into a one-hot selector.
    always_comb begin
        sel_bit = '0;
        sel_bit[op_idx] = 1'b1;
    end

    // Update the mask: full load first, then the single-bit operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data;
        end else if (op_en) begin
            if (op_kind == rrid_pkg::LINE_ENABLE) mask_q <= mask_q | sel_bit;
            else                                  mask_q <= mask_q & ~sel_bit;
        end
    end

    // R8: a single-line operation leaves every other bit as it was.
    p_line_op_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !wr_en) |=> (((mask_q ^ $past(mask_q)) & ~$past(sel_bit)) == '0));

    // R7: a full load shows its data after the edge.
    p_full_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == $past(wr_data)));
endmodule

// File: rtl/rrid_rr_pick.sv
// Rotating first-pending search. Starting at ptr, it returns the first set bit
// of pending in increasing index order, wrapping around.
// Assumes: NUM_LINES is a power of two, so index arithmetic wraps by width.
module rrid_rr_pick #(
    parameter int NUM_LINES = 32,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] pending,
    input  logic [IDX_W-1:0]     ptr,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);
    logic [IDX_W-1:0] cand;

    // Walk the lines from ptr and keep the first pending one.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        cand = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            cand = ptr + IDX_W'(k);
            if (!hit && pending[cand]) begin
                hit = 1'b1;
                idx = cand;
            end
        end
    end
endmodule

// File: rtl/rrid_remap.sv
// Maps a raw line index into the internal or the cascaded external number space.
// Assumes: EXT_FIRST <= EXT_LAST < NUM_LINES when cascading is enabled.
module rrid_remap #(
    parameter int NUM_LINES = 32,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_FIRST = 8,
    parameter int EXT_LAST = 11,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic [IDX_W-1:0] raw_idx,
    output logic             is_ext,
    output logic [IDX_W-1:0] num
);
    localparam logic [IDX_W-1:0] LO = IDX_W'(EXT_FIRST);
    localparam logic [IDX_W-1:0] HI = IDX_W'(EXT_LAST);

    generate
        if (CASCADE_EN) begin : g_casc
            // Check the window and rebase the index inside it.
            always_comb begin
                is_ext = (raw_idx >= LO) && (raw_idx <= HI);
                num    = is_ext ? (raw_idx - LO) : raw_idx;
            end
        end else begin : g_flat
            // Without cascading every line is internal.
            always_comb begin
                is_ext = 1'b0;
                num    = raw_idx;
            end
        end
    endgenerate
endmodule

// File: rtl/rr_irq_dispatch.sv
// Top of the round-robin masked interrupt dispatcher. It forms the pending set,
// drives the summary request, and answers each service request with a registered grant.
// Assumes: NUM_LINES is 32 or 64, raw_status is level-held, and the reset is synchronous active-low.
module rr_irq_dispatch #(
    parameter int NUM_LINES = 32,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_FIRST = 8,
    parameter int EXT_LAST = 11,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_status,
    input  logic                 mask_wr_en,
    input  logic [NUM_LINES-1:0] mask_wr_data,
    input  logic                 line_op_en,
    input  logic                 line_op_set,
    input  logic [IDX_W-1:0]     line_op_idx,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] pending,
    output logic                 cpu_irq,
    input  logic                 svc_req,
    output logic                 grant_valid,
    output logic                 grant_ext,
    output logic [IDX_W-1:0]     grant_num
);
    logic [IDX_W-1:0]     ptr_q;
    logic                 pick_hit;
    logic [IDX_W-1:0]     pick_idx;
    logic                 map_ext;
    logic [IDX_W-1:0]     map_num;
    logic [IDX_W-1:0]     gnt_raw_q;
    logic [NUM_LINES-1:0] pend_prev;

    rrid_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr_en),
        .wr_data (mask_wr_data),
        .op_en   (line_op_en),
        .op_kind (rrid_pkg::line_op_e'(line_op_set)),
        .op_idx  (line_op_idx),
        .mask_q  (mask_q)
    );

    // Gate the sources with the mask and reduce them to the summary request.
    always_comb begin
        pending = raw_status & mask_q;
        cpu_irq = |pending;
    end

    rrid_rr_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .pending (pending),
        .ptr     (ptr_q),
        .hit     (pick_hit),
        .idx     (pick_idx)
    );

    rrid_remap #(
        .NUM_LINES  (NUM_LINES),
        .CASCADE_EN (CASCADE_EN),
        .EXT_FIRST  (EXT_FIRST),
        .EXT_LAST   (EXT_LAST)
    ) u_remap (
        .raw_idx (pick_idx),
        .is_ext  (map_ext),
        .num     (map_num)
    );

    // Register the grant and move the pointer past the granted line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            grant_valid <= 1'b0;
            grant_ext   <= 1'b0;
            grant_num   <= '0;
            gnt_raw_q   <= '0;
        end else begin
            grant_valid <= svc_req && pick_hit;
            if (svc_req && pick_hit) begin
                ptr_q     <= pick_idx + 1'b1;
                grant_ext <= map_ext;
                grant_num <= map_num;
                gnt_raw_q <= pick_idx;
            end
        end
    end

    // Keep the previous pending set for the grant-legality check.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_prev <= '0;
        else        pend_prev <= pending;
    end

    // R4: a grant names a line that was pending at the request edge.
    p_grant_was_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> pend_prev[gnt_raw_q]);

    // R5: the pointer sits one past the granted raw index.
    p_ptr_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (ptr_q == IDX_W'(gnt_raw_q + 1'b1)));

    // R3: a request with nothing pending gives no grant and keeps the pointer.
    p_empty_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !cpu_irq) |=> (!grant_valid && $stable(ptr_q)));

    // R9: no request, no grant, and the pointer is unchanged.
    p_idle_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_req |=> (!grant_valid && $stable(ptr_q)));

    // R6: an external number never exceeds the window size.
    p_ext_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_ext) |-> (int'(grant_num) <= EXT_LAST - EXT_FIRST));
endmodule

// File: tb/rr_irq_dispatch_tb.sv
// Bench: a behavioural reference model updated on each rising edge, compared
// against the design on each falling edge.
module rr_irq_dispatch_tb;
    localparam int N  = 32;
    localparam int IW = $clog2(N);
    localparam int EF = 8;
    localparam int EL = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  raw_status = '0;
    logic          mask_wr_en = 1'b0;
    logic [N-1:0]  mask_wr_data = '0;
    logic          line_op_en = 1'b0;
    logic          line_op_set = 1'b0;
    logic [IW-1:0] line_op_idx = '0;
    logic [N-1:0]  mask_q, pending;
    logic          cpu_irq, svc_req = 1'b0;
    logic          grant_valid, grant_ext;
    logic [IW-1:0] grant_num;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rr_irq_dispatch #(.NUM_LINES(N), .CASCADE_EN(1'b1), .EXT_FIRST(EF), .EXT_LAST(EL)) u_dut (
        .clk(clk), .rst_n(rst_n), .raw_status(raw_status),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .line_op_en(line_op_en), .line_op_set(line_op_set), .line_op_idx(line_op_idx),
        .mask_q(mask_q), .pending(pending), .cpu_irq(cpu_irq),
        .svc_req(svc_req), .grant_valid(grant_valid), .grant_ext(grant_ext),
        .grant_num(grant_num)
    );

    // Reference model state.
    int           m_ptr = 0;
    logic [N-1:0] m_mask = '0;
    bit           m_gv = 0, m_ext = 0;
    int           m_num = 0;
    string        gv_tag = "R2", mask_tag = "R2";

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        logic [N-1:0] pend;
        if (!rst_n) begin
            m_ptr = 0; m_mask = '0; m_gv = 0; gv_tag = "R2"; mask_tag = "R2";
        end else begin
            pend = raw_status & m_mask;
            m_gv = 0;
            if (!svc_req) gv_tag = "R9";
            else if (pend == '0) gv_tag = "R3";
            else begin
                gv_tag = "R4";
                for (int k = 0; k < N; k++) begin
                    int c;
                    c = (m_ptr + k) % N;
                    if (!m_gv && pend[c]) begin
                        m_gv = 1;
                        m_ptr = (c + 1) % N;
                        if (c >= EF && c <= EL) begin m_ext = 1; m_num = c - EF; end
                        else begin m_ext = 0; m_num = c; end
                    end
                end
            end
            if (mask_wr_en) begin m_mask = mask_wr_data; mask_tag = "R7"; end
            else if (line_op_en) begin
                m_mask[line_op_idx] = line_op_set;
                mask_tag = "R8";
            end
        end
    end

    // Compare design outputs with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 pending", longint'(pending), longint'(raw_status & m_mask));
            check("R1 cpu_irq", longint'(cpu_irq), longint'(|(raw_status & m_mask)));
            check(gv_tag, longint'(grant_valid), longint'(m_gv));
            check(mask_tag, longint'(mask_q), longint'(m_mask));
            if (m_gv) begin
                check("R6 ext flag", longint'(grant_ext), longint'(m_ext));
                check("R5 R6 grant number", longint'(grant_num), longint'(m_num));
            end
        end
    end

    task automatic step(input bit svc, input logic [N-1:0] raw);
        @(posedge clk); #1;
        svc_req = svc; raw_status = raw;
        mask_wr_en = 1'b0; line_op_en = 1'b0;
    endtask

    task automatic write_mask(input logic [N-1:0] d);
        @(posedge clk); #1;
        svc_req = 1'b0; mask_wr_en = 1'b1; mask_wr_data = d; line_op_en = 1'b0;
    endtask

    task automatic line_op(input bit set, input int idx, input bit also_wr, input logic [N-1:0] d);
        @(posedge clk); #1;
        svc_req = 1'b0; line_op_en = 1'b1; line_op_set = set; line_op_idx = IW'(idx);
        mask_wr_en = also_wr; mask_wr_data = d;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R2: state after reset, checked before release.
        check("R2 mask reset", longint'(mask_q), 0);
        check("R2 grant reset", longint'(grant_valid), 0);
        rst_n = 1'b1;
        // R3: a request with an empty mask gives no grant.
        step(1, 32'hFFFF_FFFF);
        step(0, 32'hFFFF_FFFF);
        write_mask(32'hFFFF_FFFF);
        // R4 R5: rotation through a sparse pattern.
        for (int i = 0; i < 6; i++) step(1, 32'h8000_0091);
        // R6: lines in and around the cascaded window.
        for (int i = 0; i < 8; i++) step(1, 32'h0000_1F80);
        // R3: nothing pending.
        step(1, '0); step(1, '0);
        // R8: single-line disable and enable, then a full write racing a line op.
        line_op(0, 9, 0, '0);
        line_op(0, 31, 0, '0);
        for (int i = 0; i < 4; i++) step(1, 32'h8000_0E00);
        line_op(1, 31, 0, '0);
        line_op(1, 3, 1, 32'h0000_00F0);
        step(0, 32'h0000_00FF);
        // R4: wrap from the top line to line 0.
        write_mask(32'hFFFF_FFFF);
        for (int i = 0; i < 5; i++) step(1, 32'h8000_0001);
        // Mixed traffic with random patterns, requests and mask changes.
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r == 0) write_mask($urandom);
            else if (r == 1) line_op($urandom_range(0, 1), int'($urandom_range(0, N - 1)), 1'b0, '0);
            else step(r > 3, $urandom & $urandom);
        end
        step(0, '0);
        @(posedge clk); #1;
        @(negedge clk); #1;
        done = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule